// File: doc/BRIEF.md
# Float to Unsigned Integer Converter

This block takes one IEEE-754 binary floating-point value and returns an unsigned integer. The value is rounded to the nearest integer, and an exact halfway case goes to the even neighbour. The 64-bit operand bus carries a half, single or double precision value, chosen by a 2-bit format code. A half or single value sits in the low bits of the bus. A width select picks a 32-bit or a 64-bit destination.

Two flags come with the result. The invalid flag reports NaN inputs, results that are too large for the selected width, and results that would be negative. The inexact flag reports that fraction bits were thrown away.

The conversion itself is a single combinational path: unpack, align and round, then a range check. A parameter places an optional register after it. The register loads when the input valid strobe is high, and its output valid is that strobe delayed by one cycle.

Top module: `fp2uint_cvt`

## Requirements
- R1: `fmt_i` selects the source format: 2'b11 is half (5-bit exponent, 10-bit fraction, in `operand_i[15:0]`), 2'b00 is single (8/23, in `operand_i[31:0]`) and 2'b01 is double (11/52, the whole bus). Operand bits above the selected format are ignored. The reserved code 2'b10 gives result 0 with the invalid flag set.
- R2: With `wide_i`=1 the result is a 64-bit unsigned integer. With `wide_i`=0 it is a 32-bit integer, zero-extended on `result_o`, so `result_o[63:32]` is always 0.
- R3: Rounding goes to the nearest integer, and an exact tie goes to the even integer: 0.5→0, 1.5→2, 2.5→2, 3.5→4.
- R4: Any NaN (quiet or signalling, of either sign) gives result 0 with `invalid_o`=1 and `inexact_o`=0.
- R5: When the rounded value is above the largest value of the selected width, and also for +infinity, `invalid_o`=1 and the result saturates to all ones of that width (0xFFFFFFFF or 0xFFFFFFFFFFFFFFFF).
- R6: A negative input whose rounded value is nonzero, and -infinity, give result 0 with `invalid_o`=1.
- R7: A negative input that rounds to zero (for example -0.4 or -0.5) gives 0 with only `inexact_o` set. Negative zero gives 0 with no flag.
- R8: `inexact_o` is 1 exactly when discarded fraction bits are nonzero and `invalid_o` is 0. The two flags are never high together.
- R9: Subnormal inputs of every format give 0 with `inexact_o`=1.
- R10: With `REG_OUT`=1, result and flags appear one cycle after a cycle with `in_valid_i`=1, and `out_valid_o` equals `in_valid_i` delayed by one cycle. The outputs hold while `in_valid_i`=0, and reset clears `out_valid_o`, the result and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operand strobe |
| fmt_i | input | 2 | Source format code |
| wide_i | input | 1 | 1: 64-bit result, 0: 32-bit result |
| operand_i | input | 64 | Floating-point operand, right-aligned |
| out_valid_o | output | 1 | Result strobe |
| result_o | output | 64 | Unsigned integer result |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The assertions are gated by `in_valid_i`. They assume that the format, width and operand inputs are driven to known values whenever the strobe is high, and that these inputs are stable across the sampling edge. The hold property also assumes that nothing but the strobe loads the output register. The bench changes every input only on the falling clock edge and pulses the strobe for one cycle per vector. The values between strobes are deliberately different, so that the hold check can catch a register that loads when it should not.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam int MANT_W = 53;
  localparam int EXP_W  = 13;
  localparam int OUT_W  = 64;
  localparam int NAR_W  = 32;

  typedef enum logic [1:0] {
    FMT_SGL = 2'b00,
    FMT_DBL = 2'b01,
    FMT_RSV = 2'b10,
    FMT_HLF = 2'b11
  } fmt_e;

  typedef struct packed {
    logic              sign;
    logic              nan;
    logic              inf;
    logic              zero;
    logic              tiny;
    logic [EXP_W-1:0]  exp;   // unbiased, two's complement
    logic [MANT_W-1:0] mant;  // hidden bit at MSB
  } unp_t;

  typedef struct packed {
    logic [OUT_W:0] mag;      // rounded magnitude, one carry bit
    logic           inexact;
    logic           huge;     // exponent beyond integer window
  } rnd_t;
endpackage

// File: rtl/fcu_field.sv
module fcu_field
  import fcu_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] bits_i,
  output unp_t           unp_o
);
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic [EW-1:0] exp_f;
  logic [FW-1:0] frac;
  logic          all1, all0, frac_nz;

  assign exp_f   = bits_i[FW +: EW];
  assign frac    = bits_i[FW-1:0];
  assign all1    = &exp_f;
  assign all0    = ~|exp_f;
  assign frac_nz = |frac;

  always_comb begin
    unp_o      = '0;
    unp_o.sign = bits_i[EW+FW];
    unp_o.nan  = all1 & frac_nz;
    unp_o.inf  = all1 & ~frac_nz;
    unp_o.zero = all0 & ~frac_nz;
    unp_o.tiny = all0 & frac_nz;
    unp_o.exp  = EXP_W'(exp_f) - EXP_W'(BIAS);
    unp_o.mant = MANT_W'({1'b1, frac}) << (MANT_W - 1 - FW);
  end
endmodule

// File: rtl/fcu_unpack.sv
module fcu_unpack
  import fcu_pkg::*;
(
  input  logic [1:0]       fmt_i,
  input  logic [OUT_W-1:0] operand_i,
  output unp_t             unp_o
);
  localparam int NF = 3;
  localparam int EWS [NF] = '{5, 8, 11};
  localparam int FWS [NF] = '{10, 23, 52};

  unp_t u [NF];

  for (genvar g = 0; g < NF; g++) begin : g_fmt
    fcu_field #(.EW(EWS[g]), .FW(FWS[g])) u_field (
      .bits_i (operand_i[EWS[g]+FWS[g]:0]),
      .unp_o  (u[g])
    );
  end

  always_comb begin
    unique case (fmt_e'(fmt_i))
      FMT_HLF: unp_o = u[0];
      FMT_SGL: unp_o = u[1];
      FMT_DBL: unp_o = u[2];
      default: begin
        unp_o     = '0;
        unp_o.nan = 1'b1;  // reserved code reported as invalid
      end
    endcase
  end
endmodule

// File: rtl/fcu_round.sv
module fcu_round
  import fcu_pkg::*;
(
  input  unp_t unp_i,
  output rnd_t rnd_o
);
  localparam int FX_W = 2 * OUT_W;
  localparam int SH_W = $clog2(FX_W);
  localparam int OFFS = OUT_W - (MANT_W - 1);

  logic signed [EXP_W-1:0] e;
  logic [SH_W-1:0]         sh;
  logic [FX_W-1:0]         fx;
  logic [OUT_W-1:0]        intp;
  logic                    guard, sticky, up;

  assign e      = unp_i.exp;
  assign sh     = SH_W'(int'(e) + OFFS);
  assign fx     = FX_W'(unp_i.mant) << sh;
  assign intp   = fx[FX_W-1:OUT_W];
  assign guard  = fx[OUT_W-1];
  assign sticky = |fx[OUT_W-2:0];
  assign up     = guard & (sticky | intp[0]);

  always_comb begin
    rnd_o = '0;
    if (unp_i.zero || unp_i.nan || unp_i.inf) begin
      rnd_o = '0;
    end else if (unp_i.tiny || int'(e) < -1) begin
      rnd_o.inexact = 1'b1;  // below one half
    end else if (int'(e) > OUT_W - 1) begin
      rnd_o.huge = 1'b1;
    end else begin
      rnd_o.mag     = {1'b0, intp} + (OUT_W+1)'(up);
      rnd_o.inexact = guard | sticky;
    end
  end
endmodule

// File: rtl/fcu_range.sv
module fcu_range
  import fcu_pkg::*;
(
  input  unp_t             unp_i,
  input  rnd_t             rnd_i,
  input  logic             wide_i,
  output logic [OUT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  logic             lim_hit, over, mag_nz;
  logic [OUT_W-1:0] sat;

  assign lim_hit = wide_i ? rnd_i.mag[OUT_W] : |rnd_i.mag[OUT_W:NAR_W];
  assign over    = rnd_i.huge | unp_i.inf | lim_hit;
  assign mag_nz  = |rnd_i.mag;
  assign sat     = wide_i ? '1 : OUT_W'({NAR_W{1'b1}});

  always_comb begin
    result_o  = '0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    if (unp_i.nan) begin
      invalid_o = 1'b1;
    end else if (unp_i.sign) begin
      if (over || mag_nz) invalid_o = 1'b1;
      else                inexact_o = rnd_i.inexact;
    end else if (over) begin
      invalid_o = 1'b1;
      result_o  = sat;
    end else begin
      result_o  = wide_i ? rnd_i.mag[OUT_W-1:0] : OUT_W'(rnd_i.mag[NAR_W-1:0]);
      inexact_o = rnd_i.inexact;
    end
  end
endmodule

// File: rtl/fp2uint_cvt.sv
module fp2uint_cvt
  import fcu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [1:0]  fmt_i,
  input  logic        wide_i,
  input  logic [63:0] operand_i,
  output logic        out_valid_o,
  output logic [63:0] result_o,
  output logic        invalid_o,
  output logic        inexact_o
);
  unp_t             unp;
  rnd_t             rnd;
  logic [OUT_W-1:0] c_res;
  logic             c_inv, c_inx;

  fcu_unpack u_unpack (
    .fmt_i     (fmt_i),
    .operand_i (operand_i),
    .unp_o     (unp)
  );

  fcu_round u_round (
    .unp_i (unp),
    .rnd_o (rnd)
  );

  fcu_range u_range (
    .unp_i     (unp),
    .rnd_i     (rnd),
    .wide_i    (wide_i),
    .result_o  (c_res),
    .invalid_o (c_inv),
    .inexact_o (c_inx)
  );

  if (REG_OUT) begin : g_reg
    logic             vld_q, inv_q, inx_q;
    logic [OUT_W-1:0] res_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        res_q <= '0;
        inv_q <= 1'b0;
        inx_q <= 1'b0;
      end else begin
        vld_q <= in_valid_i;
        if (in_valid_i) begin
          res_q <= c_res;
          inv_q <= c_inv;
          inx_q <= c_inx;
        end
      end
    end

    assign out_valid_o = vld_q;
    assign result_o    = res_q;
    assign invalid_o   = inv_q;
    assign inexact_o   = inx_q;

    assert_valid_lag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> out_valid_o == $past(in_valid_i));
    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> $stable(result_o) && $stable(invalid_o) && $stable(inexact_o));
  end else begin : g_comb
    assign out_valid_o = in_valid_i;
    assign result_o    = c_res;
    assign invalid_o   = c_inv;
    assign inexact_o   = c_inx;
  end

  assert_flag_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> !(c_inv && c_inx));
  assert_nan_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && unp.nan |-> c_inv && c_res == '0);
  assert_narrow_ext_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !wide_i |-> c_res[OUT_W-1:NAR_W] == '0);
  assert_neg_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && unp.sign |-> c_res == '0);
endmodule

// File: tb/tb_fp2uint_cvt.sv
`timescale 1ns/1ps
module tb_fp2uint_cvt;
  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  fmt;
    logic        wide;
    logic [63:0] op;
    logic [63:0] res;
    logic        inv;
    logic        inx;
  } vec_t;

  localparam int NV = 43;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] N32  = 64'h0000_0000_FFFF_FFFF;

  // R3 ties/rounding, R8 exactness, R1 formats, R2 width, R5 overflow,
  // R4 NaN, R6 negative, R7 negative-to-zero, R9 subnormal
  localparam vec_t VECS [NV] = '{
    '{8'd3, 2'b01, 1'b0, 64'h4004000000000000, 64'd2, 1'b0, 1'b1},
    '{8'd3, 2'b01, 1'b0, 64'h400C000000000000, 64'd4, 1'b0, 1'b1},
    '{8'd3, 2'b01, 1'b0, 64'h3FE0000000000000, 64'd0, 1'b0, 1'b1},
    '{8'd3, 2'b01, 1'b0, 64'h3FF8000000000000, 64'd2, 1'b0, 1'b1},
    '{8'd8, 2'b01, 1'b0, 64'h3FF0000000000000, 64'd1, 1'b0, 1'b0},
    '{8'd8, 2'b01, 1'b1, 64'h0000000000000000, 64'd0, 1'b0, 1'b0},
    '{8'd3, 2'b00, 1'b1, 64'h0000000040200000, 64'd2, 1'b0, 1'b1},
    '{8'd3, 2'b00, 1'b1, 64'h0000000040600000, 64'd4, 1'b0, 1'b1},
    '{8'd1, 2'b11, 1'b0, 64'h0000000000004100, 64'd2, 1'b0, 1'b1},
    '{8'd1, 2'b11, 1'b0, 64'h0000000000004300, 64'd4, 1'b0, 1'b1},
    '{8'd1, 2'b11, 1'b0, 64'h0000000000007BFF, 64'hFFE0, 1'b0, 1'b0},
    '{8'd1, 2'b10, 1'b1, 64'h3FF0000000000000, 64'd0, 1'b1, 1'b0},
    '{8'd1, 2'b00, 1'b0, 64'hDEADBEEF40200000, 64'd2, 1'b0, 1'b1},
    '{8'd8, 2'b00, 1'b0, 64'h000000003F400000, 64'd1, 1'b0, 1'b1},
    '{8'd8, 2'b01, 1'b0, 64'h3FD0000000000000, 64'd0, 1'b0, 1'b1},
    '{8'd2, 2'b01, 1'b1, 64'h41F0000000000000, 64'h100000000, 1'b0, 1'b0},
    '{8'd5, 2'b01, 1'b0, 64'h41F0000000000000, N32, 1'b1, 1'b0},
    '{8'd5, 2'b01, 1'b0, 64'h41EFFFFFFFF00000, N32, 1'b1, 1'b0},
    '{8'd3, 2'b01, 1'b0, 64'h41EFFFFFFFD00000, 64'hFFFFFFFE, 1'b0, 1'b1},
    '{8'd2, 2'b01, 1'b1, 64'h43EFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFF800, 1'b0, 1'b0},
    '{8'd5, 2'b01, 1'b0, 64'h43EFFFFFFFFFFFFF, N32, 1'b1, 1'b0},
    '{8'd5, 2'b01, 1'b1, 64'h43F0000000000000, ONES, 1'b1, 1'b0},
    '{8'd5, 2'b01, 1'b1, 64'h7FF0000000000000, ONES, 1'b1, 1'b0},
    '{8'd5, 2'b11, 1'b0, 64'h0000000000007C00, N32, 1'b1, 1'b0},
    '{8'd4, 2'b01, 1'b1, 64'h7FF8000000000000, 64'd0, 1'b1, 1'b0},
    '{8'd4, 2'b11, 1'b0, 64'h0000000000007E00, 64'd0, 1'b1, 1'b0},
    '{8'd4, 2'b01, 1'b1, 64'h7FF0000000000001, 64'd0, 1'b1, 1'b0},
    '{8'd4, 2'b00, 1'b1, 64'h00000000FFC00000, 64'd0, 1'b1, 1'b0},
    '{8'd6, 2'b01, 1'b1, 64'hBFF0000000000000, 64'd0, 1'b1, 1'b0},
    '{8'd6, 2'b00, 1'b0, 64'h00000000BFC00000, 64'd0, 1'b1, 1'b0},
    '{8'd6, 2'b01, 1'b1, 64'hFFF0000000000000, 64'd0, 1'b1, 1'b0},
    '{8'd7, 2'b01, 1'b0, 64'hBFD999999999999A, 64'd0, 1'b0, 1'b1},
    '{8'd7, 2'b01, 1'b1, 64'hBFE0000000000000, 64'd0, 1'b0, 1'b1},
    '{8'd7, 2'b01, 1'b1, 64'h8000000000000000, 64'd0, 1'b0, 1'b0},
    '{8'd7, 2'b00, 1'b0, 64'h0000000080000000, 64'd0, 1'b0, 1'b0},
    '{8'd9, 2'b11, 1'b1, 64'h0000000000000001, 64'd0, 1'b0, 1'b1},
    '{8'd9, 2'b00, 1'b0, 64'h0000000000000001, 64'd0, 1'b0, 1'b1},
    '{8'd9, 2'b01, 1'b1, 64'h000FFFFFFFFFFFFF, 64'd0, 1'b0, 1'b1},
    '{8'd9, 2'b01, 1'b0, 64'h8000000000000001, 64'd0, 1'b0, 1'b1},
    '{8'd2, 2'b01, 1'b1, 64'h4330000000000001, 64'h0010000000000001, 1'b0, 1'b0},
    '{8'd5, 2'b00, 1'b0, 64'h000000004F800000, N32, 1'b1, 1'b0},
    '{8'd2, 2'b00, 1'b1, 64'h000000004F800000, 64'h100000000, 1'b0, 1'b0},
    '{8'd2, 2'b00, 1'b0, 64'h000000004F7FFFFF, 64'hFFFFFF00, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  fmt = 2'b01;
  logic        wide = 1'b0;
  logic [63:0] op = '0;
  logic        out_valid, inv, inx;
  logic [63:0] res;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fp2uint_cvt #(.REG_OUT(1'b1)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .fmt_i       (fmt),
    .wide_i      (wide),
    .operand_i   (op),
    .out_valid_o (out_valid),
    .result_o    (res),
    .invalid_o   (inv),
    .inexact_o   (inx)
  );

  task automatic check(input string tag, input logic [63:0] a_res, input logic a_inv,
                       input logic a_inx, input logic [63:0] e_res, input logic e_inv,
                       input logic e_inx);
    n_run++;
    if (a_res !== e_res || a_inv !== e_inv || a_inx !== e_inx) begin
      n_fail++;
      $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
               tag, a_res, a_inv, a_inx, e_res, e_inv, e_inx);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    @(negedge clk);
    fmt = v.fmt; wide = v.wide; op = v.op; in_valid = 1'b1;
    @(negedge clk);
    check($sformatf("R%0d vec%0d", v.req, idx), res, inv, inx, v.res, v.inv, v.inx);
    check($sformatf("R10 valid vec%0d", idx), {63'd0, out_valid}, 1'b0, 1'b0, 64'd1, 1'b0, 1'b0);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset out", res, inv, inx, 64'd0, 1'b0, 1'b0);
    check("R10 reset valid", {63'd0, out_valid}, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R10: outputs hold without strobe
    run_vec(VECS[0], 0);
    fmt = 2'b01; wide = 1'b1; op = 64'h7FF0000000000000;
    @(negedge clk);
    check("R10 hold out", res, inv, inx, 64'd2, 1'b0, 1'b1);
    check("R10 hold valid", {63'd0, out_valid}, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0);

    // R10: reset clears a loaded result
    @(negedge clk);
    fmt = 2'b01; wide = 1'b1; op = 64'h43F0000000000000; in_valid = 1'b1;
    @(negedge clk);
    check("R10 pre-reset", res, inv, inx, ONES, 1'b1, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R10 reset clear", res, inv, inx, 64'd0, 1'b0, 1'b0);
    check("R10 reset valid clr", {63'd0, out_valid}, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule